// File: doc/BRIEF.md
# Transmit Frame FIFO with Threshold Start

This block sits on the transmit side of a small Ethernet MAC. Software pushes 32-bit words through a register write port. The first word of each frame holds the frame's data length in its low half and the first two header bytes in its high half. The block checks that length, packs the words into a 2048-byte buffer and decides when enough of the frame is present to begin sending. It then streams the frame out one byte per handshake on a valid/ready interface, and can pad a short frame with zero bytes up to the 60-byte minimum.

Sending starts in one of two ways. The first is automatic: after a data write, when a programmable fill threshold and a length-based completeness test are both met. The second is an explicit request write. Two interrupt status bits report a rejected length and a finished transmission. Acknowledging the error bit also discards whatever is buffered. While a frame is streaming, the block raises `busy`, and it ignores data writes and requests.

Register writes use `reg_sel` as follows: 0 data, 1 acknowledge, 2 control, 3 threshold, 4 request.

Top module: `tx_frame_fifo`

## Requirements
- R1: When the buffer is empty, a data write (sel 0) whose low 16 bits exceed 2032 sets the error status bit (`irq_tx_err`, acknowledge bit 1) and the word is not stored. A length of 2032 or less is accepted.
- R2: Each accepted word occupies 4 buffer bytes, least significant byte first. A word arriving when fewer than 4 bytes are free is dropped, and no stored byte changes.
- R3: A frame is complete when the buffered byte count is at least length + 16, plus 4 more when automatic CRC (control bit 2) is clear. The requirement never exceeds 2048.
- R4: The threshold register (sel 3, bits 5:0) enables automatic start only when its value is below 63. It is met when the buffered byte count is at least 32 × value + 4.
- R5: After a data write that leaves the threshold met and the frame complete, `busy` and `m_valid` are high on the next cycle. Otherwise no automatic start occurs.
- R6: A request write (sel 4) with bit 0 set starts sending on the next cycle whatever the threshold, provided the buffer holds at least one word. It is ignored when the buffer is empty.
- R7: The sent frame starts at buffer byte 2 (skipping the length bytes) and is length + 14 bytes long, never more than 2046. Bytes beyond those written are sent as zero.
- R8: With padding enabled (control bit 1), a frame shorter than 60 bytes is extended to 60 bytes by zero bytes.
- R9: Bytes move only on `m_valid && m_ready`. `m_data` and `m_last` hold while stalled, and `m_last` marks the final byte. After it is accepted, the buffer is empty and the empty status bit (`irq_tx_empty`, acknowledge bit 2) is set.
- R10: An acknowledge write (sel 1) clears each status bit written as 1. Writing bit 1 while idle also empties the buffer, so the next data word is a new length word.
- R11: `busy` is high from start until the final byte is accepted. Data writes and requests made meanwhile have no effect.
- R12: After reset, no frame is sending, both status bits are clear, the buffer is empty, the threshold reads 63 (no automatic start), and padding and automatic CRC are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 data, 1 acknowledge, 2 control, 3 threshold, 4 request |
| reg_wdata | input | 32 | Register write data |
| m_valid | output | 1 | Output byte valid |
| m_data | output | 8 | Output byte |
| m_last | output | 1 | Final byte of the frame |
| m_ready | input | 1 | Sink accepts the byte |
| busy | output | 1 | Frame being sent; data writes and requests ignored |
| irq_tx_err | output | 1 | Length-error status bit |
| irq_tx_empty | output | 1 | Frame-sent status bit |

## Verification
The bench probes the exact byte counts where each start condition flips: one word short of and exactly at the completeness point, the 2048-byte cap on a 2032-byte frame, and a threshold that becomes the later condition. A design off by one word would start a cycle early or late, or never start at all on the capped frame. It also fills the buffer past full and then checks the first header bytes, which an index that wraps would overwrite. It stresses padding under backpressure, where wrong zero insertion or a stall that moves data shows up as a byte mismatch. Finally, it writes data while busy and after a flush, then probes whether the next word is taken as a length; a design that stored those words would misread the next frame.

// File: rtl/txff_pkg.sv
package txff_pkg;

    typedef enum logic [2:0] {
        SEL_DATA = 3'd0,
        SEL_ACK  = 3'd1,
        SEL_CTRL = 3'd2,
        SEL_THR  = 3'd3,
        SEL_REQ  = 3'd4
    } reg_sel_e;

    localparam int IRQ_ERR_BIT   = 1;
    localparam int IRQ_EMPTY_BIT = 2;
    localparam int CTRL_PAD_BIT  = 1;
    localparam int CTRL_CRC_BIT  = 2;
    localparam int REQ_GO_BIT    = 0;
    localparam int LEN_W         = 16;
    localparam int THR_W         = 6;
    localparam int THR_OFF       = 63;

    typedef struct packed {
        logic crc_auto;
        logic pad_en;
    } tx_ctrl_t;

    typedef enum logic {
        SND_IDLE,
        SND_STREAM
    } snd_state_e;

    // bytes that must be buffered before a frame of data length len is whole
    function automatic int need_bytes(int len, logic crc_auto, int buf_bytes);
        int n;
        n = len + 16 + (crc_auto ? 0 : 4);
        return (n > buf_bytes) ? buf_bytes : n;
    endfunction

    function automatic int thr_level(int thr);
        return 32 * thr + 4;
    endfunction

    // bytes placed on the stream for a frame of data length len
    function automatic int frame_bytes(int len, logic pad_en, int min_frame,
                                       int hdr, int cap);
        int f;
        f = len + hdr;
        if (pad_en && f < min_frame) f = min_frame;
        return (f > cap) ? cap : f;
    endfunction

endpackage

// File: rtl/txff_store.sv
module txff_store #(
    parameter int BUF_BYTES = 2048,
    parameter int CNT_W     = $clog2(BUF_BYTES + 1),
    parameter int BA_W      = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [31:0]      wr_word,
    input  logic             flush,
    output logic             room,
    output logic [CNT_W-1:0] fill,
    output logic [15:0]      len_q,
    input  logic [BA_W-1:0]  rd_addr,
    output logic [7:0]       rd_byte
);
    localparam int WORDS = BUF_BYTES / 4;
    localparam int AW    = $clog2(WORDS);

    logic [31:0]   mem [WORDS];
    logic [AW-1:0] wr_idx;
    logic          do_wr;
    logic [31:0]   rd_word;

    assign room   = (fill <= CNT_W'(BUF_BYTES - 4));
    assign wr_idx = fill[AW+1:2];
    assign do_wr  = wr_en && room && !flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill  <= '0;
            len_q <= '0;
        end else if (flush) begin
            fill <= '0;
        end else if (do_wr) begin
            fill <= fill + CNT_W'(4);
            if (fill == '0) len_q <= wr_word[15:0];
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_idx] <= wr_word;
    end

    assign rd_word = mem[rd_addr[BA_W-1:2]];

    always_comb begin
        unique case (rd_addr[1:0])
            2'd0:    rd_byte = rd_word[7:0];
            2'd1:    rd_byte = rd_word[15:8];
            2'd2:    rd_byte = rd_word[23:16];
            default: rd_byte = rd_word[31:24];
        endcase
    end
endmodule

// File: rtl/txff_start.sv
module txff_start
    import txff_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic [CNT_W-1:0] fill_nx,
    input  logic [15:0]      len,
    input  logic             crc_auto,
    input  logic [THR_W-1:0] thr,
    output logic             go
);
    logic thr_on, thr_met, whole;

    always_comb begin
        thr_on  = int'(thr) < THR_OFF;
        thr_met = int'(fill_nx) >= thr_level(int'(thr));
        whole   = int'(fill_nx) >= need_bytes(int'(len), crc_auto, BUF_BYTES);
        go      = thr_on && thr_met && whole;
    end
endmodule

// File: rtl/txff_sender.sv
module txff_sender
    import txff_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int MIN_FRAME = 60,
    parameter int HDR_BYTES = 14,
    parameter int CNT_W     = $clog2(BUF_BYTES + 1),
    parameter int BA_W      = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [15:0]      len,
    input  logic             pad_en,
    input  logic [CNT_W-1:0] fill,
    output logic [BA_W-1:0]  rd_addr,
    input  logic [7:0]       rd_byte,
    input  logic             m_ready,
    output logic             m_valid,
    output logic [7:0]       m_data,
    output logic             m_last,
    output logic             done,
    output logic             busy
);
    localparam int LEN_SKIP = 2;

    snd_state_e       state;
    logic [CNT_W-1:0] idx, flen, dlen, pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SND_IDLE;
            idx   <= '0;
            flen  <= '0;
            dlen  <= '0;
        end else begin
            unique case (state)
                SND_IDLE: if (start) begin
                    state <= SND_STREAM;
                    idx   <= '0;
                    dlen  <= CNT_W'(int'(len) + HDR_BYTES);
                    flen  <= CNT_W'(frame_bytes(int'(len), pad_en, MIN_FRAME,
                                                HDR_BYTES, BUF_BYTES - LEN_SKIP));
                end
                SND_STREAM: if (m_ready) begin
                    if (idx == flen - CNT_W'(1)) state <= SND_IDLE;
                    idx <= idx + CNT_W'(1);
                end
                default: state <= SND_IDLE;
            endcase
        end
    end

    assign pos     = idx + CNT_W'(LEN_SKIP);
    assign rd_addr = pos[BA_W-1:0];
    assign m_valid = (state == SND_STREAM);
    assign busy    = m_valid;
    assign m_last  = m_valid && (idx == flen - CNT_W'(1));
    assign m_data  = (idx >= dlen || pos >= fill) ? 8'h00 : rd_byte;
    assign done    = m_valid && m_ready && m_last;
endmodule

// File: rtl/tx_frame_fifo.sv
module tx_frame_fifo
    import txff_pkg::*;
#(
    parameter int BUF_BYTES    = 2048,
    parameter int MAX_DATA_LEN = 2032,
    parameter int MIN_FRAME    = 60,
    parameter int HDR_BYTES    = 14
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic        m_valid,
    output logic [7:0]  m_data,
    output logic        m_last,
    input  logic        m_ready,
    output logic        busy,
    output logic        irq_tx_err,
    output logic        irq_tx_empty
);
    localparam int CNT_W = $clog2(BUF_BYTES + 1);
    localparam int BA_W  = $clog2(BUF_BYTES);

    reg_sel_e         sel;
    tx_ctrl_t         ctrl_q;
    logic [THR_W-1:0] thr_q;
    logic [CNT_W-1:0] fill_w, fill_nx;
    logic [15:0]      len_q, len_cand;
    logic             room, first, len_bad, wr_data, accept;
    logic             auto_ok, auto_go, man_go, start, ack_flush, flush, done;
    logic [BA_W-1:0]  rd_addr;
    logic [7:0]       rd_byte;

    assign sel = reg_sel_e'(reg_sel);

    always_comb begin
        wr_data   = reg_wr && (sel == SEL_DATA) && !busy;
        first     = (fill_w == '0);
        len_cand  = first ? reg_wdata[15:0] : len_q;
        len_bad   = first && (int'(reg_wdata[15:0]) > MAX_DATA_LEN);
        accept    = wr_data && !len_bad && room;
        fill_nx   = accept ? fill_w + CNT_W'(4) : fill_w;
        auto_go   = wr_data && !len_bad && auto_ok;
        man_go    = reg_wr && (sel == SEL_REQ) && reg_wdata[REQ_GO_BIT]
                    && !busy && !first;
        start     = auto_go || man_go;
        ack_flush = reg_wr && (sel == SEL_ACK) && reg_wdata[IRQ_ERR_BIT] && !busy;
        flush     = ack_flush || done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q       <= '0;
            thr_q        <= THR_W'(THR_OFF);
            irq_tx_err   <= 1'b0;
            irq_tx_empty <= 1'b0;
        end else begin
            if (reg_wr && sel == SEL_CTRL) begin
                ctrl_q.pad_en   <= reg_wdata[CTRL_PAD_BIT];
                ctrl_q.crc_auto <= reg_wdata[CTRL_CRC_BIT];
            end
            if (reg_wr && sel == SEL_THR) thr_q <= reg_wdata[THR_W-1:0];
            if (reg_wr && sel == SEL_ACK) begin
                if (reg_wdata[IRQ_ERR_BIT])   irq_tx_err   <= 1'b0;
                if (reg_wdata[IRQ_EMPTY_BIT]) irq_tx_empty <= 1'b0;
            end
            if (wr_data && len_bad) irq_tx_err   <= 1'b1;
            if (done)               irq_tx_empty <= 1'b1;
        end
    end

    txff_store #(.BUF_BYTES(BUF_BYTES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_data && !len_bad),
        .wr_word (reg_wdata),
        .flush   (flush),
        .room    (room),
        .fill    (fill_w),
        .len_q   (len_q),
        .rd_addr (rd_addr),
        .rd_byte (rd_byte)
    );

    txff_start #(.BUF_BYTES(BUF_BYTES)) u_start (
        .fill_nx  (fill_nx),
        .len      (len_cand),
        .crc_auto (ctrl_q.crc_auto),
        .thr      (thr_q),
        .go       (auto_ok)
    );

    txff_sender #(
        .BUF_BYTES (BUF_BYTES),
        .MIN_FRAME (MIN_FRAME),
        .HDR_BYTES (HDR_BYTES)
    ) u_send (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .len     (len_q),
        .pad_en  (ctrl_q.pad_en),
        .fill    (fill_w),
        .rd_addr (rd_addr),
        .rd_byte (rd_byte),
        .m_ready (m_ready),
        .m_valid (m_valid),
        .m_data  (m_data),
        .m_last  (m_last),
        .done    (done),
        .busy    (busy)
    );
endmodule

// File: rtl/txff_checker.sv
module txff_checker #(
    parameter int BUF_BYTES    = 2048,
    parameter int MAX_DATA_LEN = 2032,
    parameter int CNT_W        = $clog2(BUF_BYTES + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [2:0]       reg_sel,
    input logic [15:0]      wlo,
    input logic             busy,
    input logic             m_valid,
    input logic             m_ready,
    input logic [7:0]       m_data,
    input logic             m_last,
    input logic             irq_tx_empty,
    input logic             irq_tx_err,
    input logic [CNT_W-1:0] fill
);
    a_r1_long_len_rejected: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 3'd0 && !busy && fill == '0 && wlo > 16'(MAX_DATA_LEN))
        |=> (irq_tx_err && fill == '0));

    a_r2_fill_bounded: assert property (@(posedge clk) disable iff (rst)
        (fill <= CNT_W'(BUF_BYTES)) && (fill[1:0] == 2'b00));

    a_r9_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

    a_r9_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
        m_last |-> m_valid);

    a_r9_empty_after_last: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_ready && m_last) |=> (!busy && irq_tx_empty && fill == '0));

    a_r11_fill_frozen_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(fill));
endmodule

bind tx_frame_fifo txff_checker #(
    .BUF_BYTES    (BUF_BYTES),
    .MAX_DATA_LEN (MAX_DATA_LEN)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .wlo          (reg_wdata[15:0]),
    .busy         (busy),
    .m_valid      (m_valid),
    .m_ready      (m_ready),
    .m_data       (m_data),
    .m_last       (m_last),
    .irq_tx_empty (irq_tx_empty),
    .irq_tx_err   (irq_tx_err),
    .fill         (fill_w)
);

// File: tb/tx_frame_fifo_tb_top.sv
`timescale 1ns/1ps
module tx_frame_fifo_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic        m_ready = 1'b1;
    logic        m_valid, m_last, busy, irq_tx_err, irq_tx_empty;
    logic [7:0]  m_data;

    always #4 clk = ~clk;

    tx_frame_fifo dut_i (
        .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_sel (reg_sel),
        .reg_wdata (reg_wdata), .m_valid (m_valid), .m_data (m_data),
        .m_last (m_last), .m_ready (m_ready), .busy (busy),
        .irq_tx_err (irq_tx_err), .irq_tx_empty (irq_tx_empty)
    );

    int    checks = 0, errors = 0;
    bit    finished = 0;
    bit    bp_mode = 0;
    string cur_req = "R12";

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    bit [7:0] fq[$];
    bit [7:0] oq[$];
    int       mlen;
    int       mthr;
    bit       mpad, mcrc, merr, memp, msend;

    task automatic model_start();
        int dl, f;
        dl = mlen + 14;
        f  = (mpad && dl < 60) ? 60 : dl;
        if (f > 2046) f = 2046;
        oq.delete();
        for (int i = 0; i < f; i++)
            oq.push_back((i < dl && i + 2 < fq.size()) ? fq[i+2] : 8'h00);
        msend = 1;
    endtask

    task automatic model_data(logic [31:0] w);
        int need;
        if (fq.size() == 0 && int'(w[15:0]) > 2032) begin
            merr = 1;
        end else begin
            if (fq.size() == 0) mlen = int'(w[15:0]);
            if (fq.size() + 4 <= 2048) begin
                fq.push_back(w[7:0]);   fq.push_back(w[15:8]);
                fq.push_back(w[23:16]); fq.push_back(w[31:24]);
            end
            need = mlen + 16 + (mcrc ? 0 : 4);
            if (need > 2048) need = 2048;
            if (mthr < 63 && fq.size() >= 32 * mthr + 4 && fq.size() >= need)
                model_start();
        end
    endtask

    always @(posedge clk) begin
        bit was_busy;
        if (rst) begin
            fq.delete(); oq.delete();
            mlen = 0; mthr = 63; mpad = 0; mcrc = 0;
            merr = 0; memp = 0; msend = 0;
        end else begin
            was_busy = msend;
            if (reg_wr) begin
                case (reg_sel)
                    3'd0: if (!was_busy) model_data(reg_wdata);
                    3'd1: begin
                        if (reg_wdata[1]) merr = 0;
                        if (reg_wdata[2]) memp = 0;
                        if (reg_wdata[1] && !was_busy) fq.delete();
                    end
                    3'd2: begin mpad = reg_wdata[1]; mcrc = reg_wdata[2]; end
                    3'd3: mthr = int'(reg_wdata[5:0]);
                    3'd4: if (reg_wdata[0] && !was_busy && fq.size() != 0) model_start();
                    default: ;
                endcase
            end
            if (was_busy && m_ready) begin
                void'(oq.pop_front());
                if (oq.size() == 0) begin
                    msend = 0;
                    fq.delete();
                    memp = 1;
                end
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(cur_req, "m_valid", m_valid, msend);
            chk(cur_req, "busy", busy, msend);
            chk(cur_req, "irq_tx_err", irq_tx_err, merr);
            chk(cur_req, "irq_tx_empty", irq_tx_empty, memp);
            if (msend) begin
                chk(cur_req, "m_data", m_data, oq[0]);
                chk(cur_req, "m_last", m_last, oq.size() == 1);
            end
        end
    end

    // sink: ready pattern and frame collector
    int cyc = 0;
    initial forever begin
        @(negedge clk);
        #1;
        cyc++;
        m_ready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
    end

    int       rx_cnt = 0, last_len = 0, frames = 0;
    bit [7:0] b0, b1, fb0, fb1;
    always @(negedge clk) begin
        #2;
        if (!rst && m_valid && m_ready) begin
            if (rx_cnt == 0) b0 = m_data;
            if (rx_cnt == 1) b1 = m_data;
            rx_cnt++;
            if (m_last) begin
                last_len = rx_cnt; fb0 = b0; fb1 = b1;
                rx_cnt = 0; frames++;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(logic [2:0] s, logic [31:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic words(int n, int seed);
        for (int i = 1; i <= n; i++) wr(3'd0, 32'h9E3779B9 * (i + seed));
    endtask

    task automatic wait_frame(int exp_len, string req);
        int f0 = frames;
        for (int k = 0; k < 8000 && frames == f0; k++) @(negedge clk);
        @(negedge clk);
        chk(req, "frame length", last_len, exp_len);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk("R12", "reset m_valid", m_valid, 0);
        chk("R12", "reset busy", busy, 0);
        chk("R12", "reset irq_tx_err", irq_tx_err, 0);
        chk("R12", "reset irq_tx_empty", irq_tx_empty, 0);

        // R12/R4/R6: default threshold never auto-starts; request does
        cur_req = "R6";
        wr(3'd0, 32'hB1A0_0006);
        words(6, 1);
        repeat (4) @(negedge clk);
        chk("R12", "no auto start with reset threshold", busy, 0);
        wr(3'd4, 32'h1);
        chk("R6", "busy after request", busy, 1);
        wait_frame(20, "R6");
        chk("R2", "first sent byte", fb0, 8'hA0);
        chk("R7", "second sent byte", fb1, 8'hB1);
        chk("R9", "empty bit set", irq_tx_empty, 1);
        wr(3'd1, 32'h4);
        chk("R10", "empty bit cleared", irq_tx_empty, 0);
        wr(3'd4, 32'h1);
        chk("R6", "request on empty buffer ignored", busy, 0);

        // R3/R5: auto CRC on, threshold 0, len 8 needs 24 bytes
        cur_req = "R5";
        wr(3'd2, 32'h4);
        wr(3'd3, 32'h0);
        wr(3'd0, 32'h1234_0008);
        words(4, 7);
        @(negedge clk);
        chk("R3", "incomplete frame not started", busy, 0);
        words(1, 9);
        chk("R5", "auto start next cycle", busy, 1);
        wait_frame(22, "R5");

        // R8/R9/R11: padding under backpressure, writes while busy dropped
        cur_req = "R8";
        bp_mode = 1;
        wr(3'd2, 32'h6);
        wr(3'd0, 32'hCAFE_000A);
        words(6, 20);
        chk("R8", "padded frame started", busy, 1);
        wr(3'd0, 32'hDEAD_0001);
        wr(3'd0, 32'hDEAD_0002);
        wr(3'd4, 32'h1);
        wait_frame(60, "R8");
        bp_mode = 0;
        cur_req = "R11";
        wr(3'd0, 32'h0000_FFFF);
        chk("R11", "buffer empty after busy writes", irq_tx_err, 1);
        wr(3'd1, 32'h2);
        chk("R10", "error bit cleared", irq_tx_err, 0);

        // R1/R2/R7: length limit, overfill, capped frame by request
        cur_req = "R1";
        wr(3'd3, 32'h3F);
        wr(3'd2, 32'h0);
        wr(3'd0, 32'h0000_07F1);
        chk("R1", "2033 rejected", irq_tx_err, 1);
        wr(3'd1, 32'h2);
        wr(3'd0, 32'hC3C2_07F0);
        chk("R1", "2032 accepted", irq_tx_err, 0);
        cur_req = "R2";
        words(511, 40);
        wr(3'd0, 32'hEEEE_EEEE);
        chk("R2", "no start when full and threshold off", busy, 0);
        wr(3'd4, 32'h1);
        wait_frame(2046, "R7");
        chk("R2", "overflow word did not overwrite start", {fb1, fb0}, 16'hC3C2);

        // R3: completeness capped at 2048 with auto CRC off
        cur_req = "R3";
        wr(3'd3, 32'h0);
        wr(3'd0, 32'h5A5A_07F0);
        words(510, 60);
        chk("R3", "511 words not enough", busy, 0);
        words(1, 700);
        chk("R3", "cap reached starts", busy, 1);
        wait_frame(2046, "R3");

        // R4: threshold level 32*2+4 = 68 bytes dominates
        cur_req = "R4";
        wr(3'd3, 32'h2);
        wr(3'd2, 32'h4);
        wr(3'd0, 32'h0102_0004);
        words(15, 80);
        chk("R4", "64 bytes below threshold", busy, 0);
        words(1, 99);
        chk("R4", "68 bytes meets threshold", busy, 1);
        wait_frame(18, "R4");

        // R10: acknowledge flush discards partial frame
        cur_req = "R10";
        wr(3'd3, 32'h3F);
        wr(3'd0, 32'h4444_0028);
        words(2, 120);
        wr(3'd1, 32'h2);
        wr(3'd3, 32'h0);
        wr(3'd0, 32'h7777_0002);
        words(3, 130);
        chk("R10", "new frame not yet complete", busy, 0);
        words(1, 140);
        chk("R10", "new frame started", busy, 1);
        wait_frame(16, "R10");
        chk("R10", "header from new frame", fb0, 8'h77);

        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule